// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets logic running on a single clock read and write an external asynchronous static RAM of 128K bytes. The host side uses a one-cycle request pulse that carries an address, a direction flag and write data. It gets back a one-cycle acknowledge and, for reads, a registered byte. The memory side drives active-low select, output-enable and write-enable strobes and the address pins. It drives the data pins through separate out, in and drive-enable signals, so a pad ring or a bench can build the bidirectional bus from them.

Every phase of an access lasts a whole number of clock cycles. Each count comes from a nanosecond minimum given as a parameter, divided by the clock period and rounded up. A read holds select and output enable low until the slower of the two access times has passed, then samples the pins. A write first settles the address with write enable high, then pulses write enable low with output enable held high, and drives data through the end of the pulse. After every access the bus is left undriven with select high until the memory's output float time has passed.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is applied and after its release, the strobes `mem_cs_n_o`, `mem_oe_n_o` and `mem_we_n_o` are 1, `mem_dq_oe_o` and `ack_o` are 0, and `rdata_o` is 0.
- R2: A read request accepted in idle drives select=0, output enable=0 and write enable=1 for RD_CYC cycles. RD_CYC is the larger of ceil(T_ADDR_ACC_NS/CLK_PERIOD_NS) and ceil(T_OE_ACC_NS/CLK_PERIOD_NS). The byte on `mem_dq_i` at the clock edge that ends the last of those cycles appears on `rdata_o` in the following cycle.
- R3: A write request accepted in idle gives, in order: one setup cycle (select=0, write enable=1, output enable=1), then WP_CYC cycles with write enable=0, then one hold cycle with write enable=1 and select=0. WP_CYC is the larger of ceil(T_WR_PULSE_NS/CLK_PERIOD_NS) and ceil(T_DATA_SETUP_NS/CLK_PERIOD_NS)+1.
- R4: Output enable is 1 in every cycle where write enable is 0, and the data pins are never driven while output enable is 0.
- R5: `mem_dq_oe_o` is 1 from the second cycle of the write-enable pulse through the hold cycle and 0 in every other cycle. While it is 1, `mem_dq_o` carries the request's write byte, and the memory stores that byte at the end of the pulse.
- R6: `mem_addr_o` takes the request address in the first cycle of an access and does not change while select stays 0.
- R7: After each access, select is 1 and the bus is released for FLT_CYC = ceil(T_FLOAT_NS/CLK_PERIOD_NS) cycles before the next request can be taken.
- R8: `ack_o` is 1 for exactly one cycle per accepted request: the first turnaround cycle, for reads and writes alike.
- R9: A request raised while an access or turnaround is in progress is dropped. It changes no strobe, address or data pin, writes nothing and causes no acknowledge.
- R10: `rdata_o` keeps its last read value through idle cycles and writes until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | One-cycle access request, taken only in idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 8 | Write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| mem_addr_o | output | 17 | Memory address pins |
| mem_cs_n_o | output | 1 | Active-low chip select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data to the pins |
| mem_dq_i | input | 8 | Data from the pins |
| mem_dq_oe_o | output | 1 | 1 = controller drives the data pins |

## Verification
The bench builds the block at a 5 ns clock with fast-grade timing: 15 ns address access, 8 ns output-enable access, 10 ns pulse width, 8 ns data setup and 7 ns float. That gives a three-cycle read wait and a two-cycle turnaround. It also gives a three-cycle write pulse whose length is set by the data-setup term rather than the pulse width, so the drive-start rule on the pulse's first cycle is tested. The behavioural memory makes its output valid only after the full address access time, so sampling even one cycle early returns a wrong byte. Requests are also raised in the middle of a busy access, and the lowest and highest addresses and all-zero and all-one bytes are covered.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_WAIT  = 3'd1,
    ST_WR_SETUP = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4,
    ST_TURN     = 3'd5
  } seq_state_e;

  // Cycles needed to cover ns at the given period, never below one.
  function automatic int cyc_ceil(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_rst_sync.sv
`timescale 1ns/1ps
module sram_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
module sram_seq_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)           cnt_d = load_val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int RD_CYC  = 3,
  parameter int WP_CYC  = 3,
  parameter int FLT_CYC = 2,
  parameter int CNT_W   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic req_we_i,
  output logic accept_o,
  output logic capture_o,
  output logic ack_o,
  output logic cs_n_o,
  output logic oe_n_o,
  output logic we_n_o,
  output logic dq_oe_o
);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] FLT_LD = CNT_W'(FLT_CYC - 1);

  seq_state_e       state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             ack_d;
  logic             cs_n_d, oe_n_d, we_n_d, drv_d;
  logic             cs_n_q, oe_n_q, we_n_q, drv_q, ack_q;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_done)
  );

  // Next state and phase timer loads.
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    ack_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          tmr_load = 1'b1;
          if (req_we_i) begin
            state_d = ST_WR_SETUP;
            tmr_val = '0;
          end else begin
            state_d = ST_RD_WAIT;
            tmr_val = RD_LD;
          end
        end
      end
      ST_RD_WAIT: begin
        if (tmr_done) begin
          state_d   = ST_TURN;
          tmr_load  = 1'b1;
          tmr_val   = FLT_LD;
          capture_o = 1'b1;
          ack_d     = 1'b1;
        end
      end
      ST_WR_SETUP: begin
        if (tmr_done) begin
          state_d  = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = WP_LD;
        end
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          state_d  = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = '0;
        end
      end
      ST_WR_HOLD: begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = FLT_LD;
        ack_d    = 1'b1;
      end
      ST_TURN: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobe decode of the coming state, registered so the pins are clean.
  always_comb begin
    cs_n_d = !(state_d inside {ST_RD_WAIT, ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
    oe_n_d = (state_d != ST_RD_WAIT);
    we_n_d = (state_d != ST_WR_PULSE);
    drv_d  = ((state_d == ST_WR_PULSE) && (state_q == ST_WR_PULSE)) ||
             (state_d == ST_WR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drv_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      drv_q   <= drv_d;
      ack_q   <= ack_d;
    end
  end

  assign cs_n_o  = cs_n_q;
  assign oe_n_o  = oe_n_q;
  assign we_n_o  = we_n_q;
  assign dq_oe_o = drv_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/sram_seq_datapath.sv
`timescale 1ns/1ps
module sram_seq_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W          = 17,
  parameter int DATA_W          = 8,
  parameter int CLK_PERIOD_NS   = 5,
  parameter int T_ADDR_ACC_NS   = 15,
  parameter int T_OE_ACC_NS     = 8,
  parameter int T_WR_PULSE_NS   = 10,
  parameter int T_DATA_SETUP_NS = 8,
  parameter int T_FLOAT_NS      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int RD_CYC  = imax(cyc_ceil(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                cyc_ceil(T_OE_ACC_NS, CLK_PERIOD_NS));
  // Data is driven from the pulse's second cycle, so setup needs one extra.
  localparam int WP_CYC  = imax(cyc_ceil(T_WR_PULSE_NS, CLK_PERIOD_NS),
                                cyc_ceil(T_DATA_SETUP_NS, CLK_PERIOD_NS) + 1);
  localparam int FLT_CYC = cyc_ceil(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = imax(RD_CYC, imax(WP_CYC, FLT_CYC));
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic rst_n_int;
  logic accept, capture;

  sram_seq_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  sram_seq_fsm #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .FLT_CYC (FLT_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_i     (req_i),
    .req_we_i  (req_we_i),
    .accept_o  (accept),
    .capture_o (capture),
    .ack_o     (ack_o),
    .cs_n_o    (mem_cs_n_o),
    .oe_n_o    (mem_oe_n_o),
    .we_n_o    (mem_we_n_o),
    .dq_oe_o   (mem_dq_oe_o)
  );

  sram_seq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_i    (accept),
    .capture_i (capture),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .dq_i      (mem_dq_i),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_dq_o),
    .rdata_o   (rdata_o)
  );
endmodule

module sram_seq_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o
);
  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> mem_oe_n_o);

  assert_we_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> !mem_cs_n_o);

  assert_drive_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> (!mem_cs_n_o && mem_oe_n_o));

  assert_drive_starts_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe_o) |-> (!mem_we_n_o && $past(!mem_we_n_o)));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));

  assert_ack_in_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (mem_cs_n_o && !mem_dq_oe_o));

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_o       (ack_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs_n_o  (mem_cs_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;
  localparam int CLK_NS = 5;
  localparam int TAA = 15, TOE = 8, TWP = 10, TDW = 8, THZ = 7;

  function automatic int up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int A     = (up(TAA) > up(TOE)) ? up(TAA) : up(TOE);
  localparam int P     = (up(TWP) > up(TDW) + 1) ? up(TWP) : up(TDW) + 1;
  localparam int F     = up(THZ);
  localparam int A_MEM = up(TAA);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        cs_n, oe_n, we_n;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i;
  logic        dq_oe;

  always #2.5 clk = ~clk;

  sram_seq_ctrl #(
    .CLK_PERIOD_NS(CLK_NS), .T_ADDR_ACC_NS(TAA), .T_OE_ACC_NS(TOE),
    .T_WR_PULSE_NS(TWP), .T_DATA_SETUP_NS(TDW), .T_FLOAT_NS(THZ)
  ) u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ack_o(ack),
    .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_cs_n_o(cs_n),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_dq_o(dq_o),
    .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string tname(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Expected per-cycle vector:
  // [47:44] tag, [43:39] {cs_n,oe_n,we_n,dq_oe,ack}, [38] rdata update,
  // [37] check address, [36:20] address, [7:0] data
  logic [47:0] expq[$];

  function automatic logic [47:0] mkv(input int tag, input logic [4:0] s,
                                      input bit rd, input bit ca,
                                      input logic [16:0] a, input logic [7:0] d);
    logic [47:0] v;
    v = '0;
    v[47:44] = 4'(tag);
    v[43:39] = s;
    v[38] = rd;
    v[37] = ca;
    v[36:20] = a;
    v[7:0] = d;
    return v;
  endfunction

  function automatic logic [7:0] dflt(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C ^ {7'd0, a[16]};
  endfunction

  logic [7:0] ref_mem [int];
  logic [7:0] dev_mem [int];
  bit         started = 0;
  bit         rvalid = 0;
  logic [7:0] exp_rdata;

  // Memory model state
  bit          rd_prev = 0, wr_prev = 0;
  int          rd_cnt = 0;
  logic [16:0] rd_addr, wr_addr;

  initial dq_i = 8'hE7;

  always @(negedge clk) begin
    logic [47:0] e;
    bit was_idle;
    bit reading, writing;
    logic [7:0] v;

    // Reference comparison
    was_idle = (expq.size() == 0);
    if (was_idle) e = mkv(started ? 9 : 1, 5'b11100, 0, 0, '0, '0);
    else          e = expq.pop_front();
    check({cs_n, oe_n, we_n, dq_oe, ack} == e[43:39], tname(int'(e[47:44])),
          int'({cs_n, oe_n, we_n, dq_oe, ack}), int'(e[43:39]));
    if (e[37]) check(mem_addr == e[36:20], "R6", int'(mem_addr), int'(e[36:20]));
    if (e[40]) check(dq_o == e[7:0], "R5", int'(dq_o), int'(e[7:0]));
    if (e[38]) begin
      exp_rdata = e[7:0];
      rvalid = 1;
      check(rdata == exp_rdata, "R2", int'(rdata), int'(exp_rdata));
    end else if (rvalid) begin
      check(rdata == exp_rdata, "R10", int'(rdata), int'(exp_rdata));
    end

    // Behavioural memory: read access time
    reading = !cs_n && !oe_n && we_n;
    if (reading && rd_prev && mem_addr == rd_addr) rd_cnt++;
    else if (reading) begin rd_cnt = 1; rd_addr = mem_addr; end
    else rd_cnt = 0;
    rd_prev = reading;
    if (rd_cnt >= A_MEM)
      dq_i = dev_mem.exists(int'(rd_addr)) ? dev_mem[int'(rd_addr)] : dflt(rd_addr);
    else
      dq_i = 8'hE7;

    // Behavioural memory: write window and contention
    if (dq_oe) check(oe_n && !cs_n, "R4", int'({cs_n, oe_n}), 2'b01);
    writing = !cs_n && !we_n;
    if (writing) begin
      check(oe_n, "R4", int'(oe_n), 1);
      if (wr_prev) check(mem_addr == wr_addr, "R6", int'(mem_addr), int'(wr_addr));
      else wr_addr = mem_addr;
    end else if (wr_prev) begin
      check(dq_oe, "R5", int'(dq_oe), 1);
      dev_mem[int'(wr_addr)] = dq_o;
    end
    wr_prev = writing;

    // Accept a request seen in an idle cycle
    if (req && was_idle && rst_n) begin
      started = 1;
      if (req_we) begin
        ref_mem[int'(req_addr)] = req_wdata;
        expq.push_back(mkv(3, 5'b01100, 0, 1, req_addr, req_wdata));
        for (int k = 2; k <= P + 1; k++)
          expq.push_back(mkv(3, {3'b010, (k >= 3), 1'b0}, 0, 1, req_addr, req_wdata));
        expq.push_back(mkv(3, 5'b01110, 0, 1, req_addr, req_wdata));
        expq.push_back(mkv(8, 5'b11101, 0, 0, '0, '0));
      end else begin
        v = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : dflt(req_addr);
        for (int k = 1; k <= A; k++)
          expq.push_back(mkv(2, 5'b00100, 0, 1, req_addr, '0));
        expq.push_back(mkv(8, 5'b11101, 1, 0, '0, v));
      end
      for (int k = 2; k <= F; k++)
        expq.push_back(mkv(7, 5'b11100, 0, 0, '0, '0));
    end
  end

  task automatic wait_idle();
    @(posedge clk);
    while (expq.size() != 0) @(posedge clk);
  endtask

  task automatic issue(input bit we, input logic [16:0] a, input logic [7:0] d);
    #1;
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req = 0;
  endtask

  task automatic access(input bit we, input logic [16:0] a, input logic [7:0] d);
    wait_idle();
    issue(we, a, d);
  endtask

  bit timeout = 0;

  initial begin
    rst_n = 0; req = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    fork
      begin
        repeat (4) @(posedge clk);
        // R1: strobes and read byte in reset
        check(cs_n && oe_n && we_n && !dq_oe && !ack, "R1",
              int'({cs_n, oe_n, we_n, dq_oe, ack}), 5'b11100);
        check(rdata == 8'h00, "R1", int'(rdata), 0);
        #1 rst_n = 1;
        repeat (4) @(posedge clk);
        check(rdata == 8'h00, "R1", int'(rdata), 0);

        // R3 R5: writes at both address ends and extreme bytes
        access(1, 17'h00000, 8'h5A);
        access(1, 17'h1FFFF, 8'hFF);
        access(1, 17'h0AAAA, 8'h00);
        access(1, 17'h15555, 8'hA5);
        // R2 R10: read back
        access(0, 17'h00000, 8'h00);
        access(0, 17'h1FFFF, 8'h00);
        access(1, 17'h01234, 8'h11);   // write between reads: R10
        access(0, 17'h0AAAA, 8'h00);
        access(0, 17'h15555, 8'h00);
        // overwrite then read
        access(1, 17'h00000, 8'h3C);
        access(0, 17'h00000, 8'h00);
        access(0, 17'h12345, 8'h00);   // never written
        // R9: request raised mid-read and mid-write is dropped
        access(0, 17'h01234, 8'h00);
        repeat (1) @(posedge clk);
        issue(1, 17'h0F0F0, 8'h77);
        access(1, 17'h00F00, 8'h42);
        @(posedge clk);
        issue(1, 17'h0F0F0, 8'h99);
        access(0, 17'h0F0F0, 8'h00);   // must return default byte
        access(0, 17'h00F00, 8'h00);
        // mixed pattern sweep
        for (int i = 0; i < 8; i++)
          access(1, 17'((i * 16411) & 17'h1FFFF), 8'(i * 37 + 1));
        for (int i = 7; i >= 0; i--)
          access(0, 17'((i * 16411) & 17'h1FFFF), 8'h00);
        wait_idle();
        repeat (4) @(posedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog expired got=%0d exp=%0d", expq.size(), 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule